// File: doc/BRIEF.md
# Four-Bit Function-Select Arithmetic/Logic Unit

A purely combinational datapath slice that takes two 4-bit operands and a 4-bit function code. It produces either one of the sixteen bitwise Boolean functions of the two operands or one of sixteen arithmetic results. A mode input chooses between the two sets. In logic mode the internal carry chain is kept out of the result bits. In arithmetic mode the carry ripples through the slice. The carry input, carry output and group lookahead outputs are all active low, so a high carry input means "no carry in".

Group propagate and generate outputs let an external lookahead unit combine several slices. An all-ones flag, decoded from the result bits, acts as an equality comparator when the slice is set to subtract with no carry in.

Top module: `aluFourBit`

## Requirements
- R1: With `logicMode`=1, `result` for `funcSel`=0..15 is, in order: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, 1111, A|~B, A|B, A.
- R2: With `logicMode`=1, `carryInN` has no effect on `result`.
- R3: With `logicMode`=0 and `carryInN`=1, `result` is (U+V) mod 16. The addend pair U,V for `funcSel`=0..15 is, in order: (A,0), (A|B,0), (A|~B,0), (0,15), (A,A&~B), (A|B,A&~B), (A,~B), (A&~B,15), (A,A&B), (A,B), (A|~B,A&B), (A&B,15), (A,A), (A|B,A), (A|~B,A), (A,15).
- R4: With `logicMode`=0 and `carryInN`=0, `result` is (U+V+1) mod 16.
- R5: `funcSel`=0110 in arithmetic mode gives A-B-1 when `carryInN`=1 and A-B when `carryInN`=0. With `carryInN`=1, `allOnes` is high exactly when A equals B.
- R6: `carryOutN` is low exactly when U+V+c reaches 16, where c=1 when `carryInN`=0. This holds in both modes.
- R7: `grpPropN` is low exactly when U|V is 1111.
- R8: `grpGenN` is low exactly when U+V reaches 16, independent of `carryInN`.
- R9: `allOnes` is high exactly when all four `result` bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| funcSel | input | 4 | Function code |
| logicMode | input | 1 | 1 selects Boolean functions, 0 selects arithmetic |
| carryInN | input | 1 | Active-low carry into bit 0 |
| result | output | 4 | Function result |
| carryOutN | output | 1 | Active-low carry out of bit 3 |
| grpPropN | output | 1 | Active-low group propagate |
| grpGenN | output | 1 | Active-low group generate |
| allOnes | output | 1 | High when every result bit is 1 |

## Verification
The checker re-evaluates the following on every input change: the plain add code against a wide sum, subtract-mode equality against a direct operand compare, the link between the rippled carry out and the group lookahead terms, and two constant logic-mode codes. The complete function tables in both modes, and carry-in indifference in logic mode, are shown only by the bench. It walks every operand pair, code, mode and carry value and compares all five outputs with values computed from the addend pairs and the Boolean table.

// File: rtl/aluPkg.sv
package aluPkg;
  // Strobes from control to datapath, one per select line plus carry handling
  typedef struct packed {
    logic orB;           // propagate term takes B
    logic orNotB;        // propagate term takes ~B
    logic genNotB;       // generate term takes A&~B
    logic genB;          // generate term takes A&B
    logic suppressCarry; // keep carries out of the result bits
    logic carryIn;       // active-high carry into bit 0
  } aluStrobe_t;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl (
  input  logic [3:0]         funcSel,
  input  logic               logicMode,
  input  logic               carryInN,
  output aluPkg::aluStrobe_t strobe
);
  always_comb begin
    strobe.orB           = funcSel[0];
    strobe.orNotB        = funcSel[1];
    strobe.genNotB       = funcSel[2];
    strobe.genB          = funcSel[3];
    strobe.suppressCarry = logicMode;
    strobe.carryIn       = ~carryInN;
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  aluPkg::aluStrobe_t strobe,
  output logic [WIDTH-1:0]   result,
  output logic               carryOut,
  output logic               grpProp,
  output logic               grpGen
);
  logic [WIDTH-1:0] propBit;
  logic [WIDTH-1:0] genBit;
  logic [WIDTH:0]   chain;
  logic [WIDTH:0]   suffixProp;
  logic [WIDTH-1:0] genTerm;

  assign chain[0]          = strobe.carryIn;
  assign suffixProp[WIDTH] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign propBit[i] = opA[i] | (opB[i] & strobe.orB) | (~opB[i] & strobe.orNotB);
    assign genBit[i]  = (opA[i] & ~opB[i] & strobe.genNotB) | (opA[i] & opB[i] & strobe.genB);
    // ripple carry
    assign chain[i+1] = genBit[i] | (propBit[i] & chain[i]);
    // logic mode returns the complement of the half-sum, arithmetic adds the carry
    assign result[i]  = propBit[i] ^ genBit[i] ^ (strobe.suppressCarry ? 1'b1 : chain[i]);
    // lookahead: generate at bit i survives if every higher bit propagates
    assign suffixProp[i] = suffixProp[i+1] & propBit[i];
    assign genTerm[i]    = genBit[i] & suffixProp[i+1];
  end

  assign carryOut = chain[WIDTH];
  assign grpProp  = suffixProp[0];
  assign grpGen   = |genTerm;
endmodule

// File: rtl/aluFourBit.sv
module aluFourBit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       funcSel,
  input  logic             logicMode,
  input  logic             carryInN,
  output logic [WIDTH-1:0] result,
  output logic             carryOutN,
  output logic             grpPropN,
  output logic             grpGenN,
  output logic             allOnes
);
  aluPkg::aluStrobe_t strobe;
  logic carryOut, grpProp, grpGen;

  aluCtrl uCtrl (
    .funcSel   (funcSel),
    .logicMode (logicMode),
    .carryInN  (carryInN),
    .strobe    (strobe)
  );

  aluDatapath #(.WIDTH(WIDTH)) uData (
    .opA      (opA),
    .opB      (opB),
    .strobe   (strobe),
    .result   (result),
    .carryOut (carryOut),
    .grpProp  (grpProp),
    .grpGen   (grpGen)
  );

  assign carryOutN = ~carryOut;
  assign grpPropN  = ~grpProp;
  assign grpGenN   = ~grpGen;
  assign allOnes   = &result;
endmodule

// File: rtl/aluFourBitChk.sv
module aluFourBitChk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       funcSel,
  input logic             logicMode,
  input logic             carryInN,
  input logic [WIDTH-1:0] result,
  input logic             carryOutN,
  input logic             grpPropN,
  input logic             grpGenN,
  input logic             allOnes
);
  logic [WIDTH:0] addRef;
  assign addRef = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, ~carryInN};

  always_comb begin
    // R3
    if (!logicMode && funcSel == 4'b1001)
      add_sum_chk: assert ({~carryOutN, result} == addRef);
    // R5
    if (!logicMode && funcSel == 4'b0110 && carryInN)
      sub_equal_chk: assert (allOnes == (opA == opB));
    // R6
    carry_lookahead_chk: assert (~carryOutN == (~grpGenN | (~grpPropN & ~carryInN)));
    // R1
    if (logicMode && funcSel == 4'b0011)
      logic_zero_chk: assert (result == '0);
    // R9
    if (logicMode && funcSel == 4'b1100)
      all_ones_flag_chk: assert (allOnes);
  end
endmodule

bind aluFourBit aluFourBitChk #(.WIDTH(WIDTH)) uChk (
  .opA(opA), .opB(opB), .funcSel(funcSel), .logicMode(logicMode), .carryInN(carryInN),
  .result(result), .carryOutN(carryOutN), .grpPropN(grpPropN), .grpGenN(grpGenN),
  .allOnes(allOnes)
);

// File: tb/tb_aluFourBit.sv
module tb_aluFourBit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rstN;
  logic [3:0] opA, opB, funcSel;
  logic       logicMode, carryInN;
  logic [3:0] result;
  logic       carryOutN, grpPropN, grpGenN, allOnes;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  aluFourBit dut (
    .opA(opA), .opB(opB), .funcSel(funcSel), .logicMode(logicMode), .carryInN(carryInN),
    .result(result), .carryOutN(carryOutN), .grpPropN(grpPropN), .grpGenN(grpGenN),
    .allOnes(allOnes)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (A=%0d B=%0d sel=%0d mode=%0d cinN=%0d)",
               req, act, exp, opA, opB, funcSel, logicMode, carryInN);
    end
  endtask

  // R3 addend pairs
  function automatic void addends(input logic [3:0] s, a, b, output logic [3:0] u, v);
    case (s)
      4'd0:  begin u = a;      v = 4'd0;   end
      4'd1:  begin u = a | b;  v = 4'd0;   end
      4'd2:  begin u = a | ~b; v = 4'd0;   end
      4'd3:  begin u = 4'd0;   v = 4'd15;  end
      4'd4:  begin u = a;      v = a & ~b; end
      4'd5:  begin u = a | b;  v = a & ~b; end
      4'd6:  begin u = a;      v = ~b;     end
      4'd7:  begin u = a & ~b; v = 4'd15;  end
      4'd8:  begin u = a;      v = a & b;  end
      4'd9:  begin u = a;      v = b;      end
      4'd10: begin u = a | ~b; v = a & b;  end
      4'd11: begin u = a & b;  v = 4'd15;  end
      4'd12: begin u = a;      v = a;      end
      4'd13: begin u = a | b;  v = a;      end
      4'd14: begin u = a | ~b; v = a;      end
      default: begin u = a;    v = 4'd15;  end
    endcase
  endfunction

  // R1 Boolean table
  function automatic logic [3:0] boolRef(input logic [3:0] s, a, b);
    case (s)
      4'd0:  return ~a;
      4'd1:  return ~(a | b);
      4'd2:  return ~a & b;
      4'd3:  return 4'd0;
      4'd4:  return ~(a & b);
      4'd5:  return ~b;
      4'd6:  return a ^ b;
      4'd7:  return a & ~b;
      4'd8:  return ~a | b;
      4'd9:  return ~(a ^ b);
      4'd10: return b;
      4'd11: return a & b;
      4'd12: return 4'd15;
      4'd13: return a | ~b;
      4'd14: return a | b;
      default: return a;
    endcase
  endfunction

  initial begin
    rstN = 1'b0;
    opA = '0; opB = '0; funcSel = '0; logicMode = 1'b1; carryInN = 1'b1;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 initial ~A", int'(result), 15);
    check("R9 initial flag", int'(allOnes), 1);
    for (int m = 0; m < 2; m++)
      for (int cn = 0; cn < 2; cn++)
        for (int s = 0; s < 16; s++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              logic [3:0] u, v, expF;
              int sum, cin;
              @(posedge clk);
              logicMode = m[0]; carryInN = cn[0]; funcSel = s[3:0];
              opA = a[3:0]; opB = b[3:0];
              @(negedge clk);
              addends(funcSel, opA, opB, u, v);
              cin = (cn == 0) ? 1 : 0;
              sum = int'(u) + int'(v) + cin;
              if (m == 1) begin
                expF = boolRef(funcSel, opA, opB);
                check((cn == 0) ? "R2 logic with carry" : "R1 logic", int'(result), int'(expF));
              end else begin
                expF = sum[3:0];
                if (s == 6) check("R5 subtract", int'(result), (a - b - 1 + cin) & 15);
                else check((cn == 0) ? "R4 arith+1" : "R3 arith", int'(result), int'(expF));
                if (s == 6 && cn == 1) check("R5 equality", int'(allOnes), (a == b) ? 1 : 0);
              end
              check("R6 carry out", int'(carryOutN), (sum >= 16) ? 0 : 1);
              check("R7 group prop", int'(grpPropN), ((u | v) == 4'hF) ? 0 : 1);
              check("R8 group gen", int'(grpGenN), ((int'(u) + int'(v)) >= 16) ? 0 : 1);
              check("R9 flag", int'(allOnes), (result == 4'hF) ? 1 : 0);
            end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule